// File: doc/BRIEF.md
# Configurable-Pipeline Single-Port RAM

This block is a single-port memory with one address bus shared by reads and writes, a write-data bus and a read-data bus. Each of the three paths into and out of the array has its own parameter that either puts a clock stage in that path or lets the signal pass straight through. The first path is the write data. The second is the address together with the enable and write-enable strobes. The third is the read result. An integrator uses these parameters to trade latency against timing slack around the storage.

The data width, address width and word count are also parameters. The word count falls back to the full span of the address bus when it is not given. It may be set lower, in which case the addresses at and above it hold nothing. A write to such an address is dropped. A read from one yields a don't-care value, which is driven as unknown.

Top module: `spram_cfg`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, a registered read output is cleared to zero, and no word of the array is written.
- R2: When `en_i` and `we_i` are both 1 at the point where the control path takes effect, `din_i` is stored at `addr_i`. A later read of that address returns it in all eight combinations of the three stage options.
- R3: While a write to an in-range address is under way, the read output shows the data being written and not the old word (write-first).
- R4: A write strobe with enable low, or an enable with the write strobe low, leaves every stored word unchanged.
- R5: A write whose address is at or above `WORDS` changes no stored word.
- R6: When the read output is registered, it holds its value while enable is low. When it is combinational, it follows the addressed word whatever the enable.
- R7: When `WORDS` is left at its default of 2**`ADDR_W`, the highest address values are usable storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for every stage and for the array |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_i | input | ADDR_W | Word address, shared by read and write |
| din_i | input | DATA_W | Write data |
| en_i | input | 1 | Memory enable |
| we_i | input | 1 | Write strobe, acted on only together with `en_i` |
| dout_o | output | DATA_W | Read data |

## Verification
The assertions assume that `en_i` and `we_i` are never unknown. They also assume that the read output is ignored whenever the addressed word is out of range, because its value is undefined there. Some configurations register the control path but not the data path, and there a stale captured write could pair with a newly driven data word. To rule this out, the stimulus starts every operation with one idle cycle. It then holds the operation stable for three clock edges, which covers the longest pipeline, before the outputs are sampled. Out-of-range addresses are only ever written. A read of one is checked only on an instance whose word count covers it, so undefined output is never compared.

// File: rtl/spram_pkg.sv
// Shared definitions for the configurable single-port RAM.
// Assumes: nothing beyond a 1800-2017 compliant tool.
package spram_pkg;

    // Selects whether a path carries a clock stage or passes through.
    typedef enum logic {
        STAGE_COMB = 1'b0,
        STAGE_REG  = 1'b1
    } stage_e;

endpackage

// File: rtl/spram_stage.sv
// Optional pipeline stage: a plain register with synchronous active-low
// reset when STAGE is STAGE_REG, otherwise a wire.
// Assumes: RST_VAL fits in W bits.
module spram_stage
    import spram_pkg::*;
#(
    parameter int              W       = 8,
    parameter stage_e          STAGE   = STAGE_REG,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    generate
        if (STAGE == STAGE_REG) begin : g_reg
            logic [W-1:0] q_r;
            // Capture the input each cycle, clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) q_r <= RST_VAL;
                else        q_r <= d_i;
            end
            assign q_o = q_r;
        end else begin : g_comb
            assign q_o = d_i;
        end
    endgenerate

endmodule

// File: rtl/spram_array.sv
// Storage array with synchronous write and asynchronous read.
// Writes are dropped during reset and for addresses at or beyond WORDS.
// A read of such an address yields unknown data.
// Assumes: control and data already aligned by the input stages.
module spram_array #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    parameter int WORDS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              en_i,
    input  logic              we_i,
    output logic [DATA_W-1:0] rd_o,
    output logic              wr_hit_o
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(WORDS);

    logic [DATA_W-1:0] mem [WORDS];
    logic              in_rng;

    // Decide whether the address lands on a stored word.
    always_comb begin
        in_rng = ({1'b0, addr_i} < LIMIT);
    end

    assign wr_hit_o = rst_n && en_i && we_i && in_rng;

    // Commit a qualified write into the array.
    always_ff @(posedge clk) begin
        if (wr_hit_o) mem[addr_i] <= din_i;
    end

    // Look up the addressed word, don't-care when out of range.
    always_comb begin
        rd_o = in_rng ? mem[addr_i] : {DATA_W{1'bx}};
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit_o |=> mem[$past(addr_i)] == $past(din_i)); // R2

    generate
        for (genvar w = 0; w < WORDS; w++) begin : g_keep
            AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
                !(en_i && we_i) |=> $stable(mem[w])); // R4
            AST_OTHER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
                (en_i && we_i && (addr_i != ADDR_W'(w))) |=> $stable(mem[w])); // R5
        end
    endgenerate

endmodule

// File: rtl/spram_out.sv
// Read-output stage. When registered, it loads the write data on a write
// (write-first), loads the array word on an enabled read, and otherwise
// holds. When combinational, it shows the array word directly.
// Assumes: wr_hit_i already includes enable, strobe, range and reset.
module spram_out
    import spram_pkg::*;
#(
    parameter int     DATA_W = 8,
    parameter stage_e STAGE  = STAGE_REG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              wr_hit_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic [DATA_W-1:0] rd_i,
    output logic [DATA_W-1:0] dout_o
);

    generate
        if (STAGE == STAGE_REG) begin : g_reg
            logic [DATA_W-1:0] q_r;
            // Update the output register on write or enabled read.
            always_ff @(posedge clk) begin
                if (!rst_n)        q_r <= '0;
                else if (wr_hit_i) q_r <= din_i;
                else if (en_i)     q_r <= rd_i;
            end
            assign dout_o = q_r;

            AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
                wr_hit_i |=> dout_o == $past(din_i)); // R3
            AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !en_i |=> $stable(dout_o)); // R6
        end else begin : g_comb
            assign dout_o = rd_i;
        end
    endgenerate

endmodule

// File: rtl/spram_cfg.sv
// Single-port RAM whose write-data, control and read-output paths are each
// independently registered or combinational.
// Assumes: WORDS <= 2**ADDR_W; en_i and we_i are never unknown.
module spram_cfg
    import spram_pkg::*;
#(
    parameter int     DATA_W     = 8,
    parameter int     ADDR_W     = 4,
    parameter int     WORDS      = 2 ** ADDR_W,
    parameter stage_e DIN_STAGE  = STAGE_REG,
    parameter stage_e CTRL_STAGE = STAGE_REG,
    parameter stage_e DOUT_STAGE = STAGE_REG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              en_i,
    input  logic              we_i,
    output logic [DATA_W-1:0] dout_o
);

    localparam int CTRL_W = ADDR_W + 2;

    logic [CTRL_W-1:0] ctrl_d, ctrl_q;
    logic [DATA_W-1:0] din_c, rd_w;
    logic [ADDR_W-1:0] addr_c;
    logic              en_c, we_c, wr_hit;

    assign ctrl_d = {en_i, we_i, addr_i};
    assign {en_c, we_c, addr_c} = ctrl_q;

    spram_stage #(.W(CTRL_W), .STAGE(CTRL_STAGE), .RST_VAL('0)) ctrl_stg_i (
        .clk(clk), .rst_n(rst_n), .d_i(ctrl_d), .q_o(ctrl_q)
    );

    spram_stage #(.W(DATA_W), .STAGE(DIN_STAGE), .RST_VAL('0)) din_stg_i (
        .clk(clk), .rst_n(rst_n), .d_i(din_i), .q_o(din_c)
    );

    spram_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORDS(WORDS)) array_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_c), .din_i(din_c),
        .en_i(en_c), .we_i(we_c), .rd_o(rd_w), .wr_hit_o(wr_hit)
    );

    spram_out #(.DATA_W(DATA_W), .STAGE(DOUT_STAGE)) out_i (
        .clk(clk), .rst_n(rst_n), .en_i(en_c), .wr_hit_i(wr_hit),
        .din_i(din_c), .rd_i(rd_w), .dout_o(dout_o)
    );

endmodule

// File: tb/spram_cfg_tb_top.sv
// Scoreboard bench: eight instances cover every stage combination, plus
// one instance at default word count. A driver task pushes expected
// values into a queue; a monitor pops and compares at each sample point.
module spram_cfg_tb_top;
    import spram_pkg::*;

    localparam int DW = 8;
    localparam int AW = 4;
    localparam int NW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          en = 1'b0;
    logic          we = 1'b0;
    logic [DW-1:0] dout_all [8];
    logic [DW-1:0] dout_dflt;

    always #5 clk = ~clk;

    generate
        for (genvar c = 0; c < 8; c++) begin : g_cfg
            spram_cfg #(
                .DATA_W(DW), .ADDR_W(AW), .WORDS(NW),
                .DIN_STAGE (((c & 1) != 0) ? STAGE_REG : STAGE_COMB),
                .CTRL_STAGE(((c & 2) != 0) ? STAGE_REG : STAGE_COMB),
                .DOUT_STAGE(((c & 4) != 0) ? STAGE_REG : STAGE_COMB)
            ) dut_i (
                .clk(clk), .rst_n(rst_n), .addr_i(addr), .din_i(din),
                .en_i(en), .we_i(we), .dout_o(dout_all[c])
            );
        end
    endgenerate

    spram_cfg #(.DATA_W(DW), .ADDR_W(AW)) dflt_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .din_i(din),
        .en_i(en), .we_i(we), .dout_o(dout_dflt)
    );

    typedef struct {
        logic [DW-1:0] ec;   // expected, combinational output
        logic [DW-1:0] er;   // expected, registered output
        logic [DW-1:0] ed;   // expected, default-size instance
        bit            cc;
        bit            cr;
        bit            cd;
        string         tag;
    } item_t;

    item_t         sb_q[$];
    event          sample_ev;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    logic [DW-1:0] model [NW];
    logic [DW-1:0] dmodel [16];
    logic [DW-1:0] last_reg = '0;
    logic [DW-1:0] last_d = '0;
    bit            reg_ok = 1'b1;

    // Monitor: pop one expected item per sample and compare all outputs.
    initial begin
        forever begin
            @(sample_ev);
            if (sb_q.size() != 0) begin
                item_t it;
                it = sb_q.pop_front();
                for (int c = 0; c < 8; c++) begin
                    bit            regd;
                    logic [DW-1:0] exp_v;
                    regd  = (c & 4) != 0;
                    exp_v = regd ? it.er : it.ec;
                    if (regd ? it.cr : it.cc) begin
                        checks++;
                        if (dout_all[c] !== exp_v) begin
                            errors++;
                            $display("FAIL %s cfg=%0d actual=%h expected=%h",
                                     it.tag, c, dout_all[c], exp_v);
                        end
                    end
                end
                if (it.cd) begin
                    checks++;
                    if (dout_dflt !== it.ed) begin
                        errors++;
                        $display("FAIL %s default-size actual=%h expected=%h",
                                 it.tag, dout_dflt, it.ed);
                    end
                end
            end
        end
    end

    // Driver: one idle cycle, then the operation held for three edges.
    task automatic do_op(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit e, input bit w, input string tag);
        item_t it;
        bit    inr;
        inr = (int'(a) < NW);
        if (e && w) begin
            if (inr) model[a] = d;
            dmodel[a] = d;
        end
        it.ec = inr ? model[a] : '0;
        it.cc = inr;
        it.er = e ? (inr ? model[a] : '0) : last_reg;
        it.cr = e ? inr : reg_ok;
        it.ed = e ? dmodel[a] : last_d;
        it.cd = 1'b1;
        it.tag = tag;
        if (e) begin
            reg_ok   = inr;
            last_reg = it.er;
        end
        last_d = it.ed;
        @(negedge clk);
        en = 1'b0;
        we = 1'b0;
        @(posedge clk);
        @(negedge clk);
        addr = a;
        din  = d;
        en   = e;
        we   = w;
        sb_q.push_back(it);
        repeat (3) @(posedge clk);
        #1 -> sample_ev;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Stimulus.
    initial begin
        item_t rst_it;
        repeat (3) @(posedge clk);
        rst_it.ec = '0; rst_it.cc = 1'b0;
        rst_it.er = '0; rst_it.cr = 1'b1;
        rst_it.ed = '0; rst_it.cd = 1'b1;
        rst_it.tag = "R1 reset";
        sb_q.push_back(rst_it);
        #1 -> sample_ev;
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NW; i++)
            do_op(AW'(i), DW'(8'h30 + i * 7), 1'b1, 1'b1, "R3 write-first");
        for (int i = 0; i < NW; i++)
            do_op(AW'(i), 8'h00, 1'b1, 1'b0, "R2 readback");

        do_op(4'd3, 8'hAA, 1'b0, 1'b1, "R4 strobe without enable");
        do_op(4'd3, 8'h00, 1'b1, 1'b0, "R4 word 3 unchanged");
        do_op(4'd4, 8'hBB, 1'b1, 1'b0, "R4 enable without strobe");

        do_op(4'd13, 8'h5A, 1'b1, 1'b1, "R7 write high address");
        do_op(4'd15, 8'hC3, 1'b1, 1'b1, "R7 write top address");
        for (int i = 0; i < NW; i++)
            do_op(AW'(i), 8'h00, 1'b1, 1'b0, "R5 out-of-range write ignored");
        do_op(4'd13, 8'h00, 1'b1, 1'b0, "R7 read high address");
        do_op(4'd15, 8'h00, 1'b1, 1'b0, "R7 read top address");

        do_op(4'd5, 8'h00, 1'b1, 1'b0, "R6 enabled read");
        do_op(4'd6, 8'h00, 1'b0, 1'b0, "R6 enable low");
        do_op(4'd2, 8'h11, 1'b1, 1'b1, "R2 overwrite");
        do_op(4'd7, 8'h00, 1'b1, 1'b0, "R2 neighbour read");
        do_op(4'd2, 8'h00, 1'b1, 1'b0, "R2 overwrite readback");

        repeat (2) @(posedge clk);
        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

endmodule